// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a clocked single-port memory of 36-bit words. Each word is four 9-bit byte lanes, which hold 32 data bits and 4 parity bits. One registered start address opens an access. A two-bit burst counter inside the block then produces the next three word addresses, so one address yields four consecutive words. Read data passes through one output register, so each word appears one clock after its address is used.

Either of two address strobes opens an access: one meant for a processor and one for a cache controller. A burst can run in linear or interleaved order. Writes can be done per lane or across the whole word. A strobe that is sampled while the chip is not selected closes the access, and the output goes quiet one clock after that. The output enable gates only the drive flag. Reads keep moving through the pipeline while it is off.

Each clock edge works on the address that the previous edge left in the counter. At the same edge the counter loads, advances or holds. A strobe edge therefore still completes one operation on the old address while it loads the new one. Back-to-back bursts need no idle cycle.

Top module: `pbs_sram`

## Requirements
- R1: While reset is applied, and after it is released with no access opened, `dout_drive` is 0.
- R2: If a strobe is sampled with the chip selected at edge k, and no read ran at edge k, `dout_drive` stays 0 after edge k. With no write inputs active at edge k+1, the word at the start address is on `dout` with `dout_drive`=1 after edge k+1.
- R3: In linear order (`order_lin`=1), each edge with `adv_n`=0 moves the low two address bits to (start + n) mod 4 for beat n.
- R4: In interleaved order (`order_lin`=0), the low two bits for beat n are the start bits XOR n.
- R5: With `adv_n`=1 and no strobe, the address holds, and each read edge returns the same word again.
- R6: A low `ads_cache_n` opens an access in the same way as a low `ads_proc_n`.
- R7: At an edge with `gw_n`=0, all four lanes of the current word are written from `din`, whatever `bwe_n` and `bsel_n` are. No read result comes out of that edge, so `dout_drive` is 0 afterwards.
- R8: At an edge with `gw_n`=1 and `bwe_n`=0, lane i (`din` bits 9i+8..9i) is written only when `bsel_n[i]`=0. The other lanes keep their contents.
- R9: An edge with no lane selected for writing is a read: either `gw_n`=1 and `bwe_n`=1, or `bwe_n`=0 with `bsel_n`=4'b1111. Such an edge changes no stored word and puts the current word on `dout`.
- R10: A strobe is sampled at edge d while the chip is not selected, meaning `ce_n`=1, `cs_hi`=0 or `cs_n`=1. After edge d the output still carries the last read. From edge d+1 on, `dout_drive` is 0 until a new access opens.
- R11: `dout_drive` is 0 whenever `oe_n`=1, and it follows `oe_n` without waiting for a clock. Reads and counter advances go on while `oe_n`=1.
- R12: Address bits above bit 1 never change within a burst, so four beats stay inside the aligned group of four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | ADDR_W | Start word address, sampled on a strobe |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_cache_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved, latched on a strobe |
| gw_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bsel_n | input | LANES | Lane selects, active low, bit i for lane i |
| oe_n | input | 1 | Output enable, active low |
| din | input | LANES*LANE_W | Write word |
| dout | output | LANES*LANE_W | Registered read word |
| dout_drive | output | 1 | Read word valid and driven |

## Verification
The assertions are checked on every cycle. They cover these points:
- how the counter reacts to a strobe, to an advance and to a hold;
- that the upper address bits stay fixed during a burst;
- that a write edge yields no read result, while a read edge always yields one;
- that the output goes quiet one clock after a deselect strobe;
- that the output enable gates the drive flag.

Only the bench scenarios can show that the right words come out. That covers the actual linear and interleaved beat sequences, which lanes a byte write merges, and that a write with no lane selected leaves memory untouched. It also covers the word that appears when the output is enabled again in the middle of a burst.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;

  // Low two address bits for a given beat of a burst.
  function automatic logic [1:0] beat_low_bits(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input burst_order_e order);
    logic [1:0] res;
    if (order == ORD_LINEAR) res = start + beat;
    else                     res = start ^ beat;
    return res;
  endfunction

endpackage

// File: rtl/pbs_burst_ctr.sv
module pbs_burst_ctr
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              selected,
  input  logic              adv_n,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              active,
  output logic [1:0]        beat,
  output logic [ADDR_W-1:0] cur_addr
);

  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  burst_order_e      order_q, order_d;
  logic              ctr_en;

  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    beat_d   = beat_q;
    order_d  = order_q;
    ctr_en   = 1'b0;
    if (strobe) begin
      ctr_en   = 1'b1;
      active_d = selected;
      beat_d   = 2'd0;
      if (selected) begin
        base_d  = addr_in;
        order_d = burst_order_e'(order_lin);
      end
    end else if (active_q && !adv_n) begin
      ctr_en = 1'b1;
      beat_d = beat_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= 2'd0;
      order_q  <= ORD_LINEAR;
    end else if (ctr_en) begin
      active_q <= active_d;
      base_q   <= base_d;
      beat_q   <= beat_d;
      order_q  <= order_d;
    end
  end

  assign active   = active_q;
  assign beat     = beat_q;
  assign cur_addr = {base_q[ADDR_W-1:2], beat_low_bits(base_q[1:0], beat_q, order_q)};

endmodule

// File: rtl/pbs_write_dec.sv
module pbs_write_dec #(
  parameter int LANES = 4
) (
  input  logic             active,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_en
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = active & (~gw_n | (~bwe_n & ~bsel_n[i]));
  end

  assign rd_en = active & ~(|lane_we);

endmodule

// File: rtl/pbs_lane_ram.sv
module pbs_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [LANE_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= mem_q[addr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/pbs_sram.sv
module pbs_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce_n,
  input  logic                    cs_hi,
  input  logic                    cs_n,
  input  logic                    ads_proc_n,
  input  logic                    ads_cache_n,
  input  logic                    adv_n,
  input  logic                    order_lin,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_drive
);

  logic              rst_meta_n, rst_sync_n;
  logic              strobe, selected;
  logic              active;
  logic [1:0]        beat;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_we;
  logic              rd_en;
  logic              rd_valid, rd_valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign strobe   = ~ads_proc_n | ~ads_cache_n;
  assign selected = ~ce_n & cs_hi & ~cs_n;

  pbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .strobe   (strobe),
    .selected (selected),
    .adv_n    (adv_n),
    .order_lin(order_lin),
    .addr_in  (addr),
    .active   (active),
    .beat     (beat),
    .cur_addr (cur_addr)
  );

  pbs_write_dec #(.LANES(LANES)) u_wdec (
    .active (active),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bsel_n (bsel_n),
    .lane_we(lane_we),
    .rd_en  (rd_en)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_ram
    pbs_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .we   (lane_we[i]),
      .rd_en(rd_en),
      .addr (cur_addr),
      .wdata(din[i*LANE_W +: LANE_W]),
      .rdata(dout[i*LANE_W +: LANE_W])
    );
  end

  always_comb rd_valid_d = rd_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_valid <= 1'b0;
    else             rd_valid <= rd_valid_d;
  end

  assign dout_drive = rd_valid & ~oe_n;

endmodule

// File: rtl/pbs_sram_checker.sv
module pbs_sram_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ads_proc_n,
  input logic              ads_cache_n,
  input logic              ce_n,
  input logic              cs_hi,
  input logic              cs_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              gw_n,
  input logic              bwe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              dout_drive,
  input logic              active,
  input logic [1:0]        beat,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              rd_valid
);

  logic strb, sel;
  assign strb = ~ads_proc_n | ~ads_cache_n;
  assign sel  = ~ce_n & cs_hi & ~cs_n;

  assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && sel) |=> (active && beat == 2'd0 && cur_addr == $past(addr)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !strb && adv_n) |=> (active && $stable(cur_addr)));

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !strb && !adv_n) |=> (beat == 2'($past(beat) + 2'd1)));

  assert_upper_fixed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !strb) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && !sel) |=> ##1 !rd_valid);

  assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_drive);

  assert_write_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !gw_n) |=> !rd_valid);

  assert_read_yields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && gw_n && bwe_n) |=> rd_valid);

endmodule

bind pbs_sram pbs_sram_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ads_proc_n (ads_proc_n),
  .ads_cache_n(ads_cache_n),
  .ce_n       (ce_n),
  .cs_hi      (cs_hi),
  .cs_n       (cs_n),
  .adv_n      (adv_n),
  .oe_n       (oe_n),
  .gw_n       (gw_n),
  .bwe_n      (bwe_n),
  .addr       (addr),
  .dout_drive (dout_drive),
  .active     (active),
  .beat       (beat),
  .cur_addr   (cur_addr),
  .rd_valid   (rd_valid)
);

// File: tb/pbs_sram_bench.sv
module pbs_sram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int WW = LN * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, cs_hi, cs_n, ads_proc_n, ads_cache_n, adv_n, order_lin;
  logic          gw_n, bwe_n, oe_n;
  logic [LN-1:0] bsel_n;
  logic [WW-1:0] din, dout;
  logic          dout_drive;

  logic [WW-1:0] model [1 << AW];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pbs_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_pbs_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs_hi(cs_hi), .cs_n(cs_n),
    .ads_proc_n(ads_proc_n), .ads_cache_n(ads_cache_n), .adv_n(adv_n),
    .order_lin(order_lin), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_drive(dout_drive)
  );

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] s, input int n,
                                             input bit lin);
    logic [1:0] lo;
    lo = lin ? 2'(s[1:0] + 2'(n)) : 2'(s[1:0] ^ 2'(n));
    return {s[AW-1:2], lo};
  endfunction

  function automatic logic [WW-1:0] pattern(input int a, input int salt);
    return WW'(a * 32'h0103_0507) ^ WW'(36'h5_A5C3_0F10 + salt);
  endfunction

  task automatic idle_inputs();
    ads_proc_n = 1'b1; ads_cache_n = 1'b1; ce_n = 1'b0; cs_hi = 1'b1; cs_n = 1'b0;
    adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1; oe_n = 1'b0;
  endtask

  task automatic open_burst(input logic [AW-1:0] a, input bit lin, input bit cache);
    addr = a; order_lin = lin;
    if (cache) ads_cache_n = 1'b0; else ads_proc_n = 1'b0;
    step();
    ads_proc_n = 1'b1; ads_cache_n = 1'b1;
  endtask

  task automatic close_burst();
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1; adv_n = 1'b1;
    ads_proc_n = 1'b0; ce_n = 1'b1;
    step();
    ads_proc_n = 1'b1; ce_n = 1'b0;
    step();
  endtask

  task automatic burst_write(input logic [AW-1:0] a, input bit lin, input int salt);
    open_burst(a, lin, 1'b0);
    gw_n = 1'b0; adv_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      din = pattern(seq_addr(a, i, lin), salt);
      model[seq_addr(a, i, lin)] = din;
      step();
    end
    close_burst();
  endtask

  task automatic burst_read(input logic [AW-1:0] a, input bit lin, input bit cache,
                            input string req);
    open_burst(a, lin, cache);
    check(dout_drive == 1'b0, {req, " R2 no data before first beat"}, WW'(dout_drive), '0);
    adv_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check(dout_drive == 1'b1, {req, " drive"}, WW'(dout_drive), WW'(1));
      check(dout == model[seq_addr(a, i, lin)], {req, " beat data"}, dout,
            model[seq_addr(a, i, lin)]);
    end
    close_burst();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_inputs(); addr = '0; order_lin = 1'b1; din = '0;
    repeat (3) step();
    check(dout_drive == 1'b0, "R1 during reset", WW'(dout_drive), '0);
    rst_n = 1'b1;
    repeat (4) step();
    check(dout_drive == 1'b0, "R1 after release", WW'(dout_drive), '0);
  endtask

  task automatic t_fill();
    for (int b = 0; b < 16; b++) burst_write(AW'(b * 4), 1'b1, 0);
  endtask

  task automatic t_linear();
    burst_read(8'h15, 1'b1, 1'b0, "R3 R12 linear wrap");
  endtask

  task automatic t_interleave();
    burst_read(8'h1E, 1'b0, 1'b1, "R4 R6 interleaved via cache strobe");
    burst_read(8'h21, 1'b0, 1'b0, "R4 interleaved start 1");
  endtask

  task automatic t_hold();
    open_burst(8'h08, 1'b1, 1'b0);
    adv_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check(dout == model[8'h08] && dout_drive, "R5 hold repeats word", dout, model[8'h08]);
    end
    adv_n = 1'b0;
    step();
    check(dout == model[8'h08], "R5 word at advance edge", dout, model[8'h08]);
    step();
    check(dout == model[8'h09], "R5 next word after advance", dout, model[8'h09]);
    close_burst();
  endtask

  task automatic t_global_write();
    logic [WW-1:0] g;
    g = 36'hC_3C3C_A5A5;
    open_burst(8'h38, 1'b1, 1'b0);
    gw_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'b0111; din = g;
    step();
    check(dout_drive == 1'b0, "R7 write edge gives no read", WW'(dout_drive), '0);
    model[8'h38] = g;
    close_burst();
    burst_read(8'h38, 1'b1, 1'b0, "R7 all lanes written");
  endtask

  task automatic t_byte_write();
    logic [WW-1:0] nw, exp;
    nw = 36'h1_2345_6789;
    exp = model[8'h30];
    for (int i = 0; i < LN; i++)
      if (i == 0 || i == 2) exp[i*LW +: LW] = nw[i*LW +: LW];
    open_burst(8'h30, 1'b1, 1'b0);
    bwe_n = 1'b0; bsel_n = 4'b1010; din = nw;
    step();
    model[8'h30] = exp;
    close_burst();
    burst_read(8'h30, 1'b1, 1'b0, "R8 lanes 0 and 2 merged");
  endtask

  task automatic t_no_write();
    open_burst(8'h34, 1'b1, 1'b0);
    bwe_n = 1'b0; bsel_n = 4'b1111; din = 36'hF_FFFF_FFFF;
    step();
    check(dout_drive && dout == model[8'h34], "R9 no lane selected reads", dout, model[8'h34]);
    bwe_n = 1'b1;
    step();
    check(dout == model[8'h34], "R9 plain read unchanged", dout, model[8'h34]);
    close_burst();
    burst_read(8'h34, 1'b1, 1'b0, "R9 memory untouched");
  endtask

  task automatic t_deselect(input int kind);
    open_burst(8'h04, 1'b1, 1'b0);
    adv_n = 1'b0;
    step();
    ads_cache_n = 1'b0;
    if (kind == 0) ce_n = 1'b1; else if (kind == 1) cs_hi = 1'b0; else cs_n = 1'b1;
    step();
    check(dout_drive && dout == model[8'h05], "R10 last read before quiet", dout, model[8'h05]);
    ads_cache_n = 1'b1; ce_n = 1'b0; cs_hi = 1'b1; cs_n = 1'b0;
    step();
    check(dout_drive == 1'b0, "R10 quiet one edge later", WW'(dout_drive), '0);
    step();
    check(dout_drive == 1'b0, "R10 stays quiet", WW'(dout_drive), '0);
    adv_n = 1'b1;
  endtask

  task automatic t_oe();
    open_burst(8'h0C, 1'b0, 1'b1);
    oe_n = 1'b1; adv_n = 1'b0;
    step();
    check(dout_drive == 1'b0, "R11 drive off while disabled", WW'(dout_drive), '0);
    step();
    oe_n = 1'b0;
    #1;
    check(dout_drive == 1'b1, "R11 drive follows enable at once", WW'(dout_drive), WW'(1));
    check(dout == model[8'h0D], "R11 pipeline advanced while disabled", dout, model[8'h0D]);
    step();
    check(dout == model[8'h0E], "R11 next beat", dout, model[8'h0E]);
    close_burst();
  endtask

  initial begin
    t_reset();
    t_fill();
    t_linear();
    t_interleave();
    t_hold();
    t_global_write();
    t_byte_write();
    t_no_write();
    for (int k = 0; k < 3; k++) t_deselect(k);
    t_oe();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule